// File: doc/BRIEF.md
# Two-Port GPIO Controller with Flash-Strobe and Sensor-Clock Decoding

This block is a register-mapped general-purpose I/O controller with two ports, A and D. Each port has an output-data register, an output-enable register and an input view. Software reaches them over a simple word-indexed bus with 32-bit data. A register window of 23 words surrounds the six port registers. The words in that window that belong to neither port are plain scratch storage.

Some port bits carry a second meaning toward attached peripherals. Three output bits of port A drive the control strobes of a raw flash device: address latch, command latch and chip enable. The device's ready pin appears in port A's input view. Port D drives a bit-banged serial sensor. A bit of the port D output word acts as the serial clock, and another bit carries the serial data sent to the sensor. A write that flips the clock bit is also flagged as a clock edge for one cycle. The sensor's serial output appears in port D's input view.

Both status pins are asynchronous to the bus clock. They pass through a two-flop synchroniser before a read can see them.

Top module: `gpio_pin_ctrl`

## Requirements
- R1: A synchronous active-low reset clears every register, the read data, the flash strobes, the sensor clock and data lines and the edge flag to zero.
- R2: A write to any in-window index other than 0x01 and 0x11 stores the full 32-bit word. A read strobe at index i loads the word into read data on the clock edge that samples it. Read data holds its value until the next read strobe.
- R3: A read of index 0x01 returns (word at 0x00 AND word at 0x02) OR'ed with the synchronised flash ready pin in bit 7. A read of index 0x11 returns (word at 0x10 AND word at 0x12) OR'ed with the synchronised sensor output pin in bit 4.
- R4: Writes to indices 0x01 and 0x11 have no effect on any register or output.
- R5: The flash address-latch, command-latch and chip-enable outputs follow bits 6, 5 and 4 of the port A output word at index 0x00. They update in the cycle after the write.
- R6: The sensor clock output follows bit 1 of the port D output word at index 0x10. The sensor data output follows bit 4 of the same word.
- R7: The edge flag is high for exactly one cycle after a write to index 0x10 that changes bit 1. A write that leaves bit 1 unchanged raises no flag.
- R8: A status pin change is captured by two flops in series. A read strobe sampled on the second clock edge after the change still returns the old level. A read strobe sampled on the third edge returns the new level.
- R9: Indices 0x17 to 0x1F lie outside the 23-word window. They read as zero, and writes to them store nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rd | input | 1 | Read strobe, sampled on the clock edge |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_idx | input | 5 | Word index of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| flash_ready_pin | input | 1 | Asynchronous ready level from the flash device |
| flash_addr_latch | output | 1 | Flash address-latch strobe |
| flash_cmd_latch | output | 1 | Flash command-latch strobe |
| flash_chip_en | output | 1 | Flash chip enable |
| sensor_rx_pin | input | 1 | Asynchronous serial output of the sensor |
| sensor_clk | output | 1 | Serial clock level toward the sensor |
| sensor_tx | output | 1 | Serial data toward the sensor |
| sensor_clk_edge | output | 1 | One-cycle flag marking a written clock transition |

## Verification
The bench builds the block with its default parameters: a 23-word window, the ready pin in bit 7, the flash strobes in bits 6 to 4, the sensor clock in bit 1 and the sensor data in bit 4. With these values the last storage word, 0x16, and the first index past the window, 0x17, can both be reached with 5-bit indices. This makes the window boundary observable from both sides. The bit positions overlap between port A's output strobes and port D's data bits. A port D write can therefore be checked for leaving the flash strobes untouched.

// File: rtl/gpio_pin_pkg.sv
// Package: shared constants and types for the two-port GPIO controller.
// Assumes a 32-bit data bus and 5-bit word indices; the index values of the
// port registers are fixed because software decodes them.
package gpio_pin_pkg;

    localparam int WORD_W = 32;
    localparam int IDX_W  = 5;

    localparam logic [IDX_W-1:0] IDX_A_OUT = 5'h00;
    localparam logic [IDX_W-1:0] IDX_A_IN  = 5'h01;
    localparam logic [IDX_W-1:0] IDX_A_OE  = 5'h02;
    localparam logic [IDX_W-1:0] IDX_D_OUT = 5'h10;
    localparam logic [IDX_W-1:0] IDX_D_IN  = 5'h11;
    localparam logic [IDX_W-1:0] IDX_D_OE  = 5'h12;

    // Flash control strobes bundled for the decode stage.
    typedef struct packed {
        logic addr_latch;
        logic cmd_latch;
        logic chip_en;
    } flash_ctl_t;

    // True for indices that are computed views rather than storage.
    function automatic logic is_view_idx(input logic [IDX_W-1:0] idx);
        return (idx == IDX_A_IN) || (idx == IDX_D_IN);
    endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
// Module: two-flop synchroniser for a vector of asynchronous status pins.
// Assumes each bit is an independent level; no multi-bit coherence is given.
module gpio_pin_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_async,
    output logic [WIDTH-1:0] pin_sync
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stable_q;

    // Capture the raw pins, then re-register them to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= pin_async;
            stable_q <= meta_q;
        end
    end

    assign pin_sync = stable_q;

    // R8
    sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (pin_sync == $past(pin_async, 2)));

endmodule

// File: rtl/gpio_pin_regs.sv
// Module: register window storage. One 32-bit word per in-window index,
// except the two input-view indices, which hold no flops and read as zero
// here (the read path builds them). Writes outside the window are dropped.
module gpio_pin_regs
    import gpio_pin_pkg::*;
#(
    parameter int WORDS = 23
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [WORD_W-1:0]       wr_data,
    output logic [WORDS*WORD_W-1:0] words_flat
);

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        if (g == int'(IDX_A_IN) || g == int'(IDX_D_IN)) begin : g_view
            assign words_flat[g*WORD_W +: WORD_W] = '0;
        end else begin : g_store
            logic [WORD_W-1:0] word_q;

            // Load the word when the write strobe addresses this index.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    word_q <= '0;
                end else if (wr_en && (int'(wr_idx) == g)) begin
                    word_q <= wr_data;
                end
            end

            assign words_flat[g*WORD_W +: WORD_W] = word_q;
        end
    end

    // R2
    store_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(wr_idx) < WORDS) && !is_view_idx(wr_idx))
        |=> (words_flat[int'($past(wr_idx))*WORD_W +: WORD_W] == $past(wr_data)));

endmodule

// File: rtl/gpio_pin_decode.sv
// Module: peripheral decode. Maps port A output bits to flash strobes and
// port D output bits to the sensor clock and data lines, and flags writes
// that flip the sensor clock bit. Assumes the output words come from
// registers, so the strobes settle one cycle after the write.
module gpio_pin_decode
    import gpio_pin_pkg::*;
#(
    parameter int AL_POS  = 6,
    parameter int CL_POS  = 5,
    parameter int CE_POS  = 4,
    parameter int SCK_POS = 1,
    parameter int TX_POS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [WORD_W-1:0] a_out_word,
    input  logic [WORD_W-1:0] d_out_word,
    output flash_ctl_t        flash_ctl,
    output logic              sensor_clk,
    output logic              sensor_tx,
    output logic              sensor_clk_edge
);

    logic clk_flip;
    logic edge_q;

    // Gather the flash strobes from the port A output word.
    always_comb begin
        flash_ctl.addr_latch = a_out_word[AL_POS];
        flash_ctl.cmd_latch  = a_out_word[CL_POS];
        flash_ctl.chip_en    = a_out_word[CE_POS];
    end

    // A port D output write whose clock bit differs from the stored one.
    assign clk_flip = wr_en && (wr_idx == IDX_D_OUT)
                      && (wr_data[SCK_POS] != d_out_word[SCK_POS]);

    // Register the flip so the flag lines up with the new clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_q <= 1'b0;
        end else begin
            edge_q <= clk_flip;
        end
    end

    assign sensor_clk      = d_out_word[SCK_POS];
    assign sensor_tx       = d_out_word[TX_POS];
    assign sensor_clk_edge = edge_q;

    // R7
    edge_has_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sensor_clk_edge |-> (sensor_clk != $past(sensor_clk)));

    // R7
    flip_has_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (sensor_clk != $past(sensor_clk))) |-> sensor_clk_edge);

    // R5
    flash_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_idx == IDX_A_OUT))
        |=> (flash_ctl.chip_en == $past(wr_data[CE_POS])));

endmodule

// File: rtl/gpio_pin_rdpath.sv
// Module: read path. Selects the addressed word, builds the two input
// views from output data, output enable and synchronised pins, and
// registers the result on each read strobe. Assumes WORDS covers 0x12.
module gpio_pin_rdpath
    import gpio_pin_pkg::*;
#(
    parameter int WORDS   = 23,
    parameter int RDY_POS = 7,
    parameter int RX_POS  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rd_en,
    input  logic [IDX_W-1:0]        rd_idx,
    input  logic [WORDS*WORD_W-1:0] words_flat,
    input  logic                    ready_sync,
    input  logic                    rx_sync,
    output logic [WORD_W-1:0]       rdata
);

    localparam int A_OUT_LSB = int'(IDX_A_OUT) * WORD_W;
    localparam int A_OE_LSB  = int'(IDX_A_OE)  * WORD_W;
    localparam int D_OUT_LSB = int'(IDX_D_OUT) * WORD_W;
    localparam int D_OE_LSB  = int'(IDX_D_OE)  * WORD_W;

    logic [WORD_W-1:0] sel_word;
    logic [WORD_W-1:0] rdata_q;

    // Pick the addressed word, then substitute the computed input views.
    always_comb begin
        sel_word = '0;
        for (int i = 0; i < WORDS; i++) begin
            if (int'(rd_idx) == i) begin
                sel_word = words_flat[i*WORD_W +: WORD_W];
            end
        end
        if (rd_idx == IDX_A_IN) begin
            sel_word = (words_flat[A_OUT_LSB +: WORD_W] & words_flat[A_OE_LSB +: WORD_W])
                       | (WORD_W'(ready_sync) << RDY_POS);
        end else if (rd_idx == IDX_D_IN) begin
            sel_word = (words_flat[D_OUT_LSB +: WORD_W] & words_flat[D_OE_LSB +: WORD_W])
                       | (WORD_W'(rx_sync) << RX_POS);
        end
    end

    // Capture the selected word when a read strobe is sampled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_en) begin
            rdata_q <= sel_word;
        end
    end

    assign rdata = rdata_q;

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (rdata == '0));

    // R2
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(rd_en)) |-> $stable(rdata));

    // R9
    outside_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (int'(rd_idx) >= WORDS)) |=> (rdata == '0));

    // R3
    ready_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (rd_idx == IDX_A_IN) && ready_sync) |=> rdata[RDY_POS]);

endmodule

// File: rtl/gpio_pin_ctrl.sv
// Module: top of the two-port GPIO controller. Connects the register
// window, the status-pin synchroniser, the peripheral decode and the read
// path. Assumes one access per cycle; a read and a write to the same index
// in one cycle return the old word.
module gpio_pin_ctrl
    import gpio_pin_pkg::*;
#(
    parameter int WIN_WORDS = 23,
    parameter int RDY_POS   = 7,
    parameter int AL_POS    = 6,
    parameter int CL_POS    = 5,
    parameter int CE_POS    = 4,
    parameter int SCK_POS   = 1,
    parameter int TX_POS    = 4,
    parameter int RX_POS    = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic [4:0]  bus_idx,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        flash_ready_pin,
    output logic        flash_addr_latch,
    output logic        flash_cmd_latch,
    output logic        flash_chip_en,
    input  logic        sensor_rx_pin,
    output logic        sensor_clk,
    output logic        sensor_tx,
    output logic        sensor_clk_edge
);

    localparam int A_OUT_LSB = int'(IDX_A_OUT) * WORD_W;
    localparam int D_OUT_LSB = int'(IDX_D_OUT) * WORD_W;

    logic [WIN_WORDS*WORD_W-1:0] words_flat;
    logic [1:0]                  pins_sync;
    flash_ctl_t                  flash_ctl;

    gpio_pin_sync #(
        .WIDTH(2)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_async({sensor_rx_pin, flash_ready_pin}),
        .pin_sync (pins_sync)
    );

    gpio_pin_regs #(
        .WORDS(WIN_WORDS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr),
        .wr_idx    (bus_idx),
        .wr_data   (bus_wdata),
        .words_flat(words_flat)
    );

    gpio_pin_decode #(
        .AL_POS (AL_POS),
        .CL_POS (CL_POS),
        .CE_POS (CE_POS),
        .SCK_POS(SCK_POS),
        .TX_POS (TX_POS)
    ) u_decode (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (bus_wr),
        .wr_idx         (bus_idx),
        .wr_data        (bus_wdata),
        .a_out_word     (words_flat[A_OUT_LSB +: WORD_W]),
        .d_out_word     (words_flat[D_OUT_LSB +: WORD_W]),
        .flash_ctl      (flash_ctl),
        .sensor_clk     (sensor_clk),
        .sensor_tx      (sensor_tx),
        .sensor_clk_edge(sensor_clk_edge)
    );

    gpio_pin_rdpath #(
        .WORDS  (WIN_WORDS),
        .RDY_POS(RDY_POS),
        .RX_POS (RX_POS)
    ) u_rdpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (bus_rd),
        .rd_idx    (bus_idx),
        .words_flat(words_flat),
        .ready_sync(pins_sync[0]),
        .rx_sync   (pins_sync[1]),
        .rdata     (bus_rdata)
    );

    assign flash_addr_latch = flash_ctl.addr_latch;
    assign flash_cmd_latch  = flash_ctl.cmd_latch;
    assign flash_chip_en    = flash_ctl.chip_en;

    // R4
    view_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && is_view_idx(bus_idx))
        |=> ($stable(flash_addr_latch) && $stable(sensor_clk) && !sensor_clk_edge));

endmodule

// File: tb/gpio_pin_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_pin_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_idx = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        flash_ready_pin = 1'b0;
    logic        flash_addr_latch, flash_cmd_latch, flash_chip_en;
    logic        sensor_rx_pin = 1'b0;
    logic        sensor_clk, sensor_tx, sensor_clk_edge;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    gpio_pin_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .flash_ready_pin(flash_ready_pin), .flash_addr_latch(flash_addr_latch),
        .flash_cmd_latch(flash_cmd_latch), .flash_chip_en(flash_chip_en),
        .sensor_rx_pin(sensor_rx_pin), .sensor_clk(sensor_clk),
        .sensor_tx(sensor_tx), .sensor_clk_edge(sensor_clk_edge)
    );

    // Entry: {is_write, index, write data, expected read data}
    localparam int NV = 20;
    localparam logic [69:0] VEC [NV] = '{
        {1'b1, 5'h00, 32'h0000_00F3, 32'h0},
        {1'b0, 5'h00, 32'h0,         32'h0000_00F3},
        {1'b1, 5'h02, 32'h0000_0F0F, 32'h0},
        {1'b0, 5'h02, 32'h0,         32'h0000_0F0F},
        {1'b0, 5'h01, 32'h0,         32'h0000_0003},
        {1'b1, 5'h10, 32'hA5A5_0000, 32'h0},
        {1'b1, 5'h12, 32'hFFFF_0000, 32'h0},
        {1'b0, 5'h11, 32'h0,         32'hA5A5_0000},
        {1'b1, 5'h05, 32'hDEAD_BEEF, 32'h0},
        {1'b0, 5'h05, 32'h0,         32'hDEAD_BEEF},
        {1'b1, 5'h16, 32'h1234_5678, 32'h0},
        {1'b0, 5'h16, 32'h0,         32'h1234_5678},
        {1'b0, 5'h17, 32'h0,         32'h0},
        {1'b1, 5'h01, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 5'h01, 32'h0,         32'h0000_0003},
        {1'b1, 5'h11, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 5'h11, 32'h0,         32'hA5A5_0000},
        {1'b1, 5'h1F, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 5'h1F, 32'h0,         32'h0},
        {1'b0, 5'h00, 32'h0,         32'h0000_00F3}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called just after a falling edge; returns at the next falling edge.
    task automatic bus_write(input logic [4:0] idx, input logic [31:0] data);
        bus_wr = 1'b1; bus_idx = idx; bus_wdata = data;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] idx, output logic [31:0] data);
        bus_rd = 1'b1; bus_idx = idx;
        @(negedge clk);
        bus_rd = 1'b0;
        data = bus_rdata;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        check("R1 rdata", bus_rdata, 32'h0);
        check("R1 strobes", {29'h0, flash_addr_latch, flash_cmd_latch, flash_chip_en}, 32'h0);
        check("R1 sensor", {29'h0, sensor_clk, sensor_tx, sensor_clk_edge}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4 R9: table walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][69]) begin
                bus_write(VEC[i][68:64], VEC[i][63:32]);
            end else begin
                bus_read(VEC[i][68:64], rd);
                check($sformatf("R2/R3/R4/R9 vec%0d", i), rd, VEC[i][31:0]);
            end
        end

        // R5: flash strobes follow port A bits 6,5,4
        bus_write(5'h00, 32'h0000_0050);
        check("R5 al/cl/ce", {29'h0, flash_addr_latch, flash_cmd_latch, flash_chip_en}, 32'h5);
        bus_write(5'h00, 32'h0000_0020);
        check("R5 al/cl/ce", {29'h0, flash_addr_latch, flash_cmd_latch, flash_chip_en}, 32'h2);
        bus_write(5'h10, 32'h0000_0070);
        check("R5 port D write leaves strobes", {29'h0, flash_addr_latch, flash_cmd_latch, flash_chip_en}, 32'h2);

        // R6 R7: clock bit flips and holds
        bus_write(5'h10, 32'h0000_0012);
        check("R7 edge on rise", {31'h0, sensor_clk_edge}, 32'h1);
        check("R6 clk/tx", {30'h0, sensor_clk, sensor_tx}, 32'h3);
        @(negedge clk);
        check("R7 edge one cycle", {31'h0, sensor_clk_edge}, 32'h0);
        bus_write(5'h10, 32'h0000_0002);
        check("R7 no edge when bit1 held", {31'h0, sensor_clk_edge}, 32'h0);
        check("R6 tx drops", {30'h0, sensor_clk, sensor_tx}, 32'h2);
        bus_write(5'h10, 32'h0000_0010);
        check("R7 edge on fall", {31'h0, sensor_clk_edge}, 32'h1);
        check("R6 clk/tx", {30'h0, sensor_clk, sensor_tx}, 32'h1);
        bus_write(5'h11, 32'h0000_0002);
        check("R4 view write no edge", {30'h0, sensor_clk, sensor_clk_edge}, 32'h0);

        // R8 R3: ready pin through the synchroniser
        bus_write(5'h02, 32'h0);
        flash_ready_pin = 1'b1;
        @(negedge clk);
        bus_read(5'h01, rd);
        check("R8 ready not yet visible", rd, 32'h0);
        bus_read(5'h01, rd);
        check("R8 R3 ready visible", rd, 32'h0000_0080);

        // R3: sensor output pin merged in bit 4 of port D view
        bus_write(5'h12, 32'h0);
        sensor_rx_pin = 1'b1;
        repeat (3) @(negedge clk);
        bus_read(5'h11, rd);
        check("R3 sensor rx bit", rd, 32'h0000_0010);

        // R2: read data holds without a strobe
        bus_write(5'h03, 32'hCAFE_0001);
        @(negedge clk);
        check("R2 rdata holds", bus_rdata, 32'h0000_0010);

        // R1: reset clears stored words
        rst_n = 1'b0;
        flash_ready_pin = 1'b0;
        sensor_rx_pin = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        bus_read(5'h03, rd);
        check("R1 word cleared", rd, 32'h0);
        check("R1 strobes after reset", {29'h0, flash_addr_latch, flash_cmd_latch, flash_chip_en}, 32'h0);

        finish_run();
    end

endmodule